// File: doc/BRIEF.md
# Clock Source Selector with Small Divider

This block holds one 32-bit source register that configures a set of clock-source slots. Each slot chooses one of seven enable-tick streams: a single PLL stream or one of six generator streams. It thins the chosen stream by a ratio taken from a four-entry divide table. Each slot produces a divided enable-tick stream, so downstream logic runs on clock enables and no derived clock is needed.

Software-style commands arrive on a single-cycle command port. One command loads the whole register. The others work on one slot at a time: change its source, request a divide ratio, or switch it on or off. Each slot remembers its last nonzero source. A slot can therefore be switched off, which zeroes its selector, and later switched back on to the same input. A parameter picks the divide table. The base table holds ratios 1, 4, 1, 2 by index. The variant table holds 1, 4, 3, 2 and so offers divide-by-3. The register can be read back at any time.

Top module: `clk_src_sel`

## Requirements
- R1: Slot i occupies register bits [5i+4:5i]. Bits [5i+4:5i+2] are its source selector and bits [5i+1:5i] its divide index. `rd_data` always shows the current register, and bits above the last slot read as 0.
- R2: Selector 0 means off, selector 1 picks `pll_tick`, and selector values 2 to 7 pick `gen_tick[0]` to `gen_tick[5]`.
- R3: The divide index picks a ratio N from the table {1,4,1,2}, or from {1,4,3,2} when VARIANT=1. An enabled slot raises its `tick_out` bit for one cycle, in the cycle after every Nth tick of its selected source. If N is lowered while a count is in progress, the next source tick completes the count.
- R4: An enable command (op 3, data bit 0 = 1) writes the slot's remembered source into its selector. A disable command (data bit 0 = 0) writes 0 into the selector.
- R5: A source command (op 1, data 1 to 7) always updates the remembered source. It writes the selector only if the slot is currently enabled; a disabled slot's selector stays 0.
- R6: A divide command (op 2) with request 1, 2 or 4 writes index 0, 3 or 1. A request of 3 writes index 2 with VARIANT=1 and index 1 (divide by 4) with the base table.
- R7: A command is rejected if its slot number is not below the slot count, if a divide request is 0 or above 4, or if a source value is 0 or above 7. A rejected command leaves the register unchanged and raises `cmd_err` for exactly the cycle after it.
- R8: While a slot's selector is 0, its `tick_out` bit stays low and its divide count is cleared. After the slot is re-enabled, its first tick needs a full N source ticks.
- R9: After reset the register holds RESET_VAL (default 0x00000009), `cmd_err` and `tick_out` are low, and each slot's remembered source is its reset selector, or 1 where that selector is 0.
- R10: A register-load command (op 0) writes every slot field from `cmd_data`. A nonzero selector in the loaded value becomes that slot's remembered source; a zero selector leaves the remembered source as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 load register, 1 set source, 2 request divide, 3 enable/disable |
| cmd_slot | input | 3 | Slot number for ops 1 to 3 |
| cmd_data | input | 32 | Register value, source, divide request or enable bit |
| rd_data | output | 32 | Current register contents |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| pll_tick | input | 1 | PLL enable-tick stream |
| gen_tick | input | 6 | Generator enable-tick streams |
| tick_out | output | 6 | Divided enable ticks, one bit per slot |

## Verification
The assertions assume that `cmd_op`, `cmd_slot` and `cmd_data` are meaningful only while `cmd_valid` is high. They also treat the tick inputs as free-running single-cycle enables with no relation to the command stream. The stimulus respects this by changing commands and ticks only between clock edges. It draws slot numbers that include the out-of-range value, and divide and source values that cross the accepted ranges, so the rejection path fires often. Tick densities are random, so counts are regularly interrupted by disable, source-change and ratio-change commands.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SRC  = 2'd1,
        OP_DIV  = 2'd2,
        OP_EN   = 2'd3
    } op_e;

    // Ratio for a divide index; the table is non-monotonic on purpose.
    function automatic logic [2:0] ratio_of(input logic [1:0] idx, input bit variant);
        case (idx)
            2'd0:    ratio_of = 3'd1;
            2'd1:    ratio_of = 3'd4;
            2'd2:    ratio_of = variant ? 3'd3 : 3'd1;
            default: ratio_of = 3'd2;
        endcase
    endfunction

    // Index for an accepted request 1..4; 3 falls back to 4 without the variant.
    function automatic logic [1:0] index_of(input logic [2:0] req, input bit variant);
        case (req)
            3'd1:    index_of = 2'd0;
            3'd2:    index_of = 2'd3;
            3'd3:    index_of = variant ? 2'd2 : 2'd1;
            default: index_of = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/clk_src_regs.sv
module clk_src_regs
    import clk_src_pkg::*;
#(
    parameter int              NUM_SLOTS = 6,
    parameter int              REG_W     = 32,
    parameter int              SLOT_W    = 3,
    parameter bit              VARIANT   = 1'b0,
    parameter logic [REG_W-1:0] RESET_VAL = 32'h0000_0009
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [SLOT_W-1:0]           cmd_slot,
    input  logic [REG_W-1:0]            cmd_data,
    output logic [REG_W-1:0]            rd_data,
    output logic                        cmd_err,
    output logic [NUM_SLOTS-1:0][2:0]   slot_sel,
    output logic [NUM_SLOTS-1:0][1:0]   slot_idx
);

    localparam int FW   = 5;
    localparam int USED = NUM_SLOTS * FW;
    localparam logic [REG_W-1:0] USED_MASK = {{(REG_W-USED){1'b0}}, {USED{1'b1}}};

    typedef struct packed {
        logic [REG_W-1:0]          regv;
        logic [NUM_SLOTS-1:0][2:0] rem;
        logic                      err;
    } st_t;

    function automatic st_t init_st();
        st_t s;
        s.regv = RESET_VAL & USED_MASK;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            s.rem[i] = (s.regv[i*FW+2 +: 3] != 3'd0) ? s.regv[i*FW+2 +: 3] : 3'd1;
        end
        s.err = 1'b0;
        return s;
    endfunction

    st_t st_d, st_q;
    op_e op;
    logic slot_ok;

    assign op      = op_e'(cmd_op);
    assign slot_ok = (int'(cmd_slot) < NUM_SLOTS);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_LOAD: begin
                    st_d.regv = cmd_data & USED_MASK;
                    for (int i = 0; i < NUM_SLOTS; i++) begin
                        if (cmd_data[i*FW+2 +: 3] != 3'd0) st_d.rem[i] = cmd_data[i*FW+2 +: 3];
                    end
                end
                OP_SRC: begin
                    if (!slot_ok || cmd_data == '0 || cmd_data > 7) begin
                        st_d.err = 1'b1;
                    end else begin
                        for (int i = 0; i < NUM_SLOTS; i++) begin
                            if (int'(cmd_slot) == i) begin
                                st_d.rem[i] = cmd_data[2:0];
                                if (st_q.regv[i*FW+2 +: 3] != 3'd0) st_d.regv[i*FW+2 +: 3] = cmd_data[2:0];
                            end
                        end
                    end
                end
                OP_DIV: begin
                    if (!slot_ok || cmd_data == '0 || cmd_data > 4) begin
                        st_d.err = 1'b1;
                    end else begin
                        for (int i = 0; i < NUM_SLOTS; i++) begin
                            if (int'(cmd_slot) == i) st_d.regv[i*FW +: 2] = index_of(cmd_data[2:0], VARIANT);
                        end
                    end
                end
                default: begin
                    if (!slot_ok) begin
                        st_d.err = 1'b1;
                    end else begin
                        for (int i = 0; i < NUM_SLOTS; i++) begin
                            if (int'(cmd_slot) == i) st_d.regv[i*FW+2 +: 3] = cmd_data[0] ? st_q.rem[i] : 3'd0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= init_st();
        else        st_q <= st_d;
    end

    assign rd_data = st_q.regv;
    assign cmd_err = st_q.err;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_fields
        assign slot_sel[g] = st_q.regv[g*FW+2 +: 3];
        assign slot_idx[g] = st_q.regv[g*FW +: 2];

        // R5
        off_src_only_remembered_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && op == OP_SRC && int'(cmd_slot) == g && slot_sel[g] == 3'd0)
            |=> (slot_sel[g] == 3'd0));

        // R9
        remembered_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.rem[g] != 3'd0);
    end

    // R7
    reject_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (rd_data == $past(rd_data)));

    // R7
    err_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid));

endmodule

// File: rtl/clk_src_div.sv
module clk_src_div
    import clk_src_pkg::*;
#(
    parameter bit VARIANT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       src_i,
    input  logic [1:0] idx_i,
    output logic       tick_o
);

    localparam int CNT_W = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } dv_t;

    dv_t dv_d, dv_q;
    logic [2:0] ratio;

    assign ratio = ratio_of(idx_i, VARIANT);

    always_comb begin
        dv_d      = dv_q;
        dv_d.tick = 1'b0;
        if (!en_i) begin
            dv_d.cnt = '0;
        end else if (src_i) begin
            if ({1'b0, dv_q.cnt} >= ratio - 3'd1) begin
                dv_d.cnt  = '0;
                dv_d.tick = 1'b1;
            end else begin
                dv_d.cnt = dv_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign tick_o = dv_q.tick;

    // R8
    idle_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!tick_o && dv_q.cnt == '0));

    // R3
    tick_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(en_i && src_i));

    // R3
    unit_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && src_i && ratio == 3'd1) |=> tick_o);

endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
    import clk_src_pkg::*;
#(
    parameter int               NUM_SLOTS = 6,
    parameter int               NUM_GEN   = 6,
    parameter int               REG_W     = 32,
    parameter int               SLOT_W    = 3,
    parameter bit               VARIANT   = 1'b0,
    parameter logic [REG_W-1:0] RESET_VAL = 32'h0000_0009
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [SLOT_W-1:0]    cmd_slot,
    input  logic [REG_W-1:0]     cmd_data,
    output logic [REG_W-1:0]     rd_data,
    output logic                 cmd_err,
    input  logic                 pll_tick,
    input  logic [NUM_GEN-1:0]   gen_tick,
    output logic [NUM_SLOTS-1:0] tick_out
);

    logic [NUM_SLOTS-1:0][2:0] slot_sel;
    logic [NUM_SLOTS-1:0][1:0] slot_idx;

    clk_src_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .REG_W     (REG_W),
        .SLOT_W    (SLOT_W),
        .VARIANT   (VARIANT),
        .RESET_VAL (RESET_VAL)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_slot  (cmd_slot),
        .cmd_data  (cmd_data),
        .rd_data   (rd_data),
        .cmd_err   (cmd_err),
        .slot_sel  (slot_sel),
        .slot_idx  (slot_idx)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic src_tick;

        always_comb begin
            src_tick = 1'b0;
            if (slot_sel[g] == 3'd1) src_tick = pll_tick;
            for (int j = 0; j < NUM_GEN; j++) begin
                if (int'(slot_sel[g]) == j + 2) src_tick = gen_tick[j];
            end
        end

        clk_src_div #(.VARIANT(VARIANT)) i_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (slot_sel[g] != 3'd0),
            .src_i  (src_tick),
            .idx_i  (slot_idx[g]),
            .tick_o (tick_out[g])
        );
    end

endmodule

// File: tb/test_clk_src_sel.sv
module test_clk_src_sel;

    localparam int NS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [2:0]  cmd_slot = 3'd0;
    logic [31:0] cmd_data = 32'd0;
    logic [31:0] rd_data;
    logic        cmd_err;
    logic        pll_tick = 1'b0;
    logic [5:0]  gen_tick = 6'd0;
    logic [5:0]  tick_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] reg_m;
    logic [2:0]  rem_m [NS];
    logic [1:0]  cnt_m [NS];
    logic [5:0]  tick_m;
    logic        err_m;
    string       rtag = "R9";
    string       ttag = "R9";

    always #4 clk = ~clk;

    clk_src_sel i_clk_src_sel (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_slot(cmd_slot), .cmd_data(cmd_data), .rd_data(rd_data),
        .cmd_err(cmd_err), .pll_tick(pll_tick), .gen_tick(gen_tick),
        .tick_out(tick_out)
    );

    function automatic int ratio_m(input logic [1:0] idx);
        case (idx)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 1;
            default: return 2;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        reg_m = 32'h0000_0009;
        for (int i = 0; i < NS; i++) begin
            rem_m[i] = (reg_m[i*5+2 +: 3] != 0) ? reg_m[i*5+2 +: 3] : 3'd1;
            cnt_m[i] = 2'd0;
        end
        tick_m = 6'd0;
        err_m  = 1'b0;
    endtask

    // One cycle: compare state, drive inputs, advance the model to the next edge.
    task automatic cyc(input bit v, input logic [1:0] op, input logic [2:0] sl,
                       input logic [31:0] d, input bit p, input logic [5:0] g);
        logic [31:0] nreg;
        logic [5:0]  ntick;
        bit          nerr;
        @(negedge clk);
        chk(rtag, rd_data, reg_m);
        chk("R7", {31'd0, cmd_err}, {31'd0, err_m});
        chk(ttag, {26'd0, tick_out}, {26'd0, tick_m});
        cmd_valid = v; cmd_op = op; cmd_slot = sl; cmd_data = d;
        pll_tick = p; gen_tick = g;
        ntick = 6'd0;
        for (int i = 0; i < NS; i++) begin
            logic [2:0] s;
            bit src;
            int r;
            s = reg_m[i*5+2 +: 3];
            r = ratio_m(reg_m[i*5 +: 2]);
            src = (s == 1) ? p : (s >= 2) ? g[s-2] : 1'b0;
            if (s == 0) cnt_m[i] = 0;
            else if (src) begin
                if (int'(cnt_m[i]) >= r - 1) begin cnt_m[i] = 0; ntick[i] = 1'b1; end
                else cnt_m[i] = cnt_m[i] + 1;
            end
        end
        nreg = reg_m; nerr = 1'b0;
        if (v) begin
            case (op)
                2'd0: begin
                    nreg = d & 32'h3FFF_FFFF;
                    for (int i = 0; i < NS; i++) if (d[i*5+2 +: 3] != 0) rem_m[i] = d[i*5+2 +: 3];
                end
                2'd1: if (sl >= NS || d == 0 || d > 7) nerr = 1'b1;
                      else begin
                          rem_m[sl] = d[2:0];
                          if (reg_m[sl*5+2 +: 3] != 0) nreg[sl*5+2 +: 3] = d[2:0];
                      end
                2'd2: if (sl >= NS || d == 0 || d > 4) nerr = 1'b1;
                      else nreg[sl*5 +: 2] = (d == 1) ? 2'd0 : (d == 2) ? 2'd3 : 2'd1;
                default: if (sl >= NS) nerr = 1'b1;
                         else nreg[sl*5+2 +: 3] = d[0] ? rem_m[sl] : 3'd0;
            endcase
        end
        reg_m = nreg; err_m = nerr; tick_m = ntick;
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        rtag = "R9"; ttag = "R9";
        cyc(0, 0, 0, 0, 0, 6'd0);
        // R10: load slot0 gen0/idx1, slot1 pll/idx0, slot2 gen3/idx3
        rtag = "R10"; ttag = "R2";
        cyc(1, 0, 0, 32'h0000_5C89, 0, 6'd0);
        for (int k = 0; k < 12; k++) cyc(0, 0, 0, 0, 1'b1, 6'($urandom));
        // R6: request 3 falls back to divide by 4, request 2 gives index 3
        rtag = "R6"; ttag = "R3";
        cyc(1, 2, 0, 3, 1, 6'h3F);
        cyc(1, 2, 1, 2, 1, 6'h3F);
        cyc(1, 2, 2, 4, 1, 6'h3F);
        for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0, 1, 6'h3F);
        // R7: rejected requests
        rtag = "R7";
        cyc(1, 2, 0, 5, 1, 6'h3F);
        cyc(1, 2, 0, 0, 1, 6'h3F);
        cyc(1, 3, 6, 1, 1, 6'h3F);
        cyc(1, 1, 1, 0, 1, 6'h3F);
        cyc(1, 1, 1, 32'h100, 1, 6'h3F);
        // R4 disable, R5 source change while off, R8 quiet while off
        rtag = "R4"; ttag = "R8";
        cyc(1, 3, 2, 0, 1, 6'h3F);
        rtag = "R5";
        cyc(1, 1, 2, 7, 1, 6'h3F);
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 1, 6'h3F);
        rtag = "R4";
        cyc(1, 3, 2, 1, 1, 6'h3F);
        for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 1, 6'h3F);
        // R1 / R3: mixed random traffic
        rtag = "R1"; ttag = "R3";
        for (int k = 0; k < 4000; k++) begin
            logic [1:0]  op;
            logic [31:0] d;
            op = 2'($urandom);
            case (op)
                2'd0: d = $urandom;
                2'd1: d = ($urandom % 8 == 0) ? $urandom : 32'($urandom % 9);
                2'd2: d = ($urandom % 8 == 0) ? $urandom : 32'($urandom % 6);
                default: d = 32'($urandom % 2);
            endcase
            cyc(($urandom % 3) == 0, op, 3'($urandom % 7), d,
                1'($urandom), 6'($urandom) & 6'($urandom | 32'h15));
        end
        cyc(0, 0, 0, 0, 0, 6'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule